// File: doc/BRIEF.md
# Four-Stage Pipeline with Split-Execute Increment

This block is a small in-order pipeline with four stages: fetch, decode, a combined execute stage, and write-back. Each instruction reads one source register, applies one of four single-operand operations, and writes one destination register. The operations are copy, subtract three, add four and add one. The execute stage holds a subtract-three unit and an add-four unit in series. A 2:1 bypass mux sits on each unit.

Add-one has no adder of its own. On its first clock in the execute stage the subtract-three unit is applied. Its result is held in a recirculation register. On the second clock the add-four unit is applied to the held value. Fetch, decode and write-back are frozen for that extra clock.

The register file is outside the block. The block drives one combinational read port and one write port. The instruction memory is also outside and is read combinationally.

Write-back results are forwarded to the execute operand. A decode-stage compare finds the dependence one instruction ahead of time. A bypass mux at the register-file read port covers the dependence two instructions back, because the register file has no internal forwarding.

Top module: `split_exec_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears the pipeline. After a clock edge with `rst` high, `imem_addr` is 0 and `rf_we` is 0. No register is written until the first instruction fetched after reset reaches write-back.
- R2: The instruction word is {op[3:0], src[AW-1:0], dst[AW-1:0]}, with dst in the low bits. The op field is one-hot: bit 0 is copy (result = src value), bit 1 subtracts 3, bit 2 adds 4 and bit 3 adds 1. All arithmetic is modulo 2^DW. Each instruction sets R[dst] to op(R[src]).
- R3: Each add-one instruction in the execute stage stalls fetch for exactly one clock. Back-to-back add-one instructions each get their own single stall clock. A program of only add-one instructions advances `imem_addr` once every two clocks. A program of only copy instructions advances it every clock. A program that alternates add-one and copy advances it eight times in twelve clocks.
- R4: An instruction that reads the destination of the instruction just before it gets the new value, through forwarding from write-back.
- R5: An instruction that reads the destination of the instruction two places before it gets the new value, through the bypass at the read port.
- R6: An add-one instruction gets the correct final value when its source is forwarded or comes from the previous add-one. Its dependents also get the correct value. On the second clock the operand is the recirculated value and the forwarding input is not used. During the stall clock the write-back outputs hold their values.
- R7: An instruction with op = 0 is a no-operation. It writes no register, even when its dst field names a register. A later reader of that register sees the older value and is not forwarded anything from the no-operation.
- R8: For any sequence of the four operations and no-operations, the final register contents equal those of a strictly sequential execution of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PW | Instruction memory address (program counter) |
| imem_data | input | 4+2*AW | Instruction word read combinationally at imem_addr |
| rf_raddr | output | AW | Register file read address (decode-stage source) |
| rf_rdata | input | DW | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | AW | Register file write address |
| rf_wdata | output | DW | Register file write data |

## Verification
Directed programs separate the different data paths. Independent operations check the arithmetic alone. Chains that depend on the previous instruction exercise forwarding from write-back. Chains that depend on the instruction two places back exercise the read-port bypass. Add-one chains and add-one juniors of a forwarded senior show whether the recirculated value is used on the second clock.

No-operations whose fields name live registers show whether a bubble is wrongly written or forwarded. Clock counts of `imem_addr` progress on add-one-only, copy-only and alternating programs show whether the stall lasts exactly one clock per add-one and never sticks or toggles. Seeded random programs over a small register set are compared with a sequential model to catch hazard combinations that the directed cases miss.

// File: rtl/spx_pkg.sv
`timescale 1ns/1ps
package spx_pkg;
    // one-hot operation vector, bit positions match the instruction op field
    localparam int OP_W  = 4;
    localparam int SUB_K = 3;
    localparam int ADD_K = 4;

    typedef struct packed {
        logic inc1;   // bit 3: add one (two clocks)
        logic add4;   // bit 2
        logic sub3;   // bit 1
        logic copy;   // bit 0
    } op_t;

    function automatic logic op_writes(op_t o);
        return |o;
    endfunction
endpackage

// File: rtl/spx_fetch.sv
`timescale 1ns/1ps
module spx_fetch #(
    parameter int PW = 6,
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [IW-1:0] imem_data,
    output logic [PW-1:0] pc,
    output logic          fd_valid,
    output logic [IW-1:0] fd_instr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            fd_valid <= 1'b0;
            fd_instr <= '0;
        end else if (en) begin
            pc       <= pc + PW'(1);
            fd_valid <= 1'b1;
            fd_instr <= imem_data;
        end
    end
endmodule

// File: rtl/spx_decode.sv
`timescale 1ns/1ps
module spx_decode
    import spx_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 16,
    localparam int IW = OP_W + 2*AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          fd_valid,
    input  logic [IW-1:0] fd_instr,
    output logic [AW-1:0] rf_raddr,
    input  logic [DW-1:0] rf_rdata,
    input  logic          wb_valid,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] wb_data,
    output logic          dx_valid,
    output op_t           dx_op,
    output logic [AW-1:0] dx_dst,
    output logic [DW-1:0] dx_opnd,
    output logic          dx_fwd
);
    op_t           id_op;
    logic [AW-1:0] id_src;
    logic [AW-1:0] id_dst;
    logic          id_valid;
    logic [DW-1:0] id_opnd;
    logic          id_hit_ex;

    assign id_op    = op_t'(fd_instr[IW-1 -: OP_W]);
    assign id_src   = fd_instr[2*AW-1 -: AW];
    assign id_dst   = fd_instr[AW-1:0];
    assign id_valid = fd_valid && op_writes(id_op);
    assign rf_raddr = id_src;

    // bypass at the read port: senior now in write-back is not yet in the file
    assign id_opnd  = (wb_valid && (wb_dst == id_src)) ? wb_data : rf_rdata;

    // compare against the senior in execute; that senior is in write-back
    // when this instruction reaches execute
    assign id_hit_ex = id_valid && dx_valid && (dx_dst == id_src);

    always_ff @(posedge clk) begin
        if (rst) begin
            dx_valid <= 1'b0;
            dx_op    <= '0;
            dx_dst   <= '0;
            dx_opnd  <= '0;
            dx_fwd   <= 1'b0;
        end else if (en) begin
            dx_valid <= id_valid;
            dx_op    <= id_valid ? id_op : '0;
            dx_dst   <= id_dst;
            dx_opnd  <= id_opnd;
            dx_fwd   <= id_hit_ex;
        end
    end
endmodule

// File: rtl/spx_execute.sv
`timescale 1ns/1ps
module spx_execute
    import spx_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dx_valid,
    input  op_t           dx_op,
    input  logic [AW-1:0] dx_dst,
    input  logic [DW-1:0] dx_opnd,
    input  logic          dx_fwd,
    output logic          stall,
    output logic          wb_valid,
    output logic [AW-1:0] wb_dst,
    output logic [DW-1:0] wb_data
);
    logic          second_q;   // add-one in its second execute clock
    logic [DW-1:0] recirc_q;
    logic [DW-1:0] opnd;
    logic          skip_sub;
    logic          skip_add;
    logic [DW-1:0] after_sub;
    logic [DW-1:0] after_add;

    assign stall    = dx_valid && dx_op.inc1 && !second_q;
    assign opnd     = second_q ? recirc_q : (dx_fwd ? wb_data : dx_opnd);
    assign skip_sub = !(dx_op.sub3 || (dx_op.inc1 && !second_q));
    assign skip_add = !(dx_op.add4 || (dx_op.inc1 && second_q));
    assign after_sub = skip_sub ? opnd : opnd - DW'(SUB_K);
    assign after_add = skip_add ? after_sub : after_sub + DW'(ADD_K);

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q <= 1'b0;
            recirc_q <= '0;
            wb_valid <= 1'b0;
            wb_dst   <= '0;
            wb_data  <= '0;
        end else begin
            second_q <= stall;
            if (stall) begin
                recirc_q <= after_sub;
            end else begin
                wb_valid <= dx_valid;
                wb_dst   <= dx_dst;
                wb_data  <= after_add;
            end
        end
    end

    AST_STALL_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall); // R3
    AST_SECOND_IS_INC1: assert property (@(posedge clk) disable iff (rst)
        second_q |-> (dx_valid && dx_op.inc1)); // R3
    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        dx_valid |-> ($countones(dx_op) == 1)); // R2
    AST_FWD_FROM_WRITER: assert property (@(posedge clk) disable iff (rst)
        (dx_valid && dx_fwd && !second_q) |-> wb_valid); // R4
    AST_WB_HELD: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(wb_data) && $stable(wb_valid) && $stable(wb_dst))); // R6
endmodule

// File: rtl/split_exec_pipe.sv
`timescale 1ns/1ps
module split_exec_pipe
    import spx_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 16,
    parameter int PW = 6,
    localparam int IW = OP_W + 2*AW
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    output logic [AW-1:0] rf_raddr,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);
    logic          stall;
    logic          advance;
    logic          fd_valid;
    logic [IW-1:0] fd_instr;
    logic          dx_valid;
    op_t           dx_op;
    logic [AW-1:0] dx_dst;
    logic [DW-1:0] dx_opnd;
    logic          dx_fwd;
    logic          wb_valid;
    logic [AW-1:0] wb_dst;
    logic [DW-1:0] wb_data;

    assign advance = !stall;

    spx_fetch #(.PW(PW), .IW(IW)) u_fetch (
        .clk(clk), .rst(rst), .en(advance), .imem_data(imem_data),
        .pc(imem_addr), .fd_valid(fd_valid), .fd_instr(fd_instr)
    );

    spx_decode #(.AW(AW), .DW(DW)) u_decode (
        .clk(clk), .rst(rst), .en(advance),
        .fd_valid(fd_valid), .fd_instr(fd_instr),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
        .dx_valid(dx_valid), .dx_op(dx_op), .dx_dst(dx_dst),
        .dx_opnd(dx_opnd), .dx_fwd(dx_fwd)
    );

    spx_execute #(.AW(AW), .DW(DW)) u_execute (
        .clk(clk), .rst(rst),
        .dx_valid(dx_valid), .dx_op(dx_op), .dx_dst(dx_dst),
        .dx_opnd(dx_opnd), .dx_fwd(dx_fwd), .stall(stall),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
    );

    assign rf_we    = wb_valid;
    assign rf_waddr = wb_dst;
    assign rf_wdata = wb_data;

    AST_PC_HOLDS_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(imem_addr)); // R3
endmodule

// File: tb/split_exec_pipe_tb.sv
`timescale 1ns/1ps
module split_exec_pipe_tb;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int PW = 6;
    localparam int IW = 4 + 2*AW;
    localparam logic [3:0] OP_MV = 4'b0001;
    localparam logic [3:0] OP_S3 = 4'b0010;
    localparam logic [3:0] OP_A4 = 4'b0100;
    localparam logic [3:0] OP_A1 = 4'b1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] imem_addr;
    logic [IW-1:0] imem_data;
    logic [AW-1:0] rf_raddr;
    logic [DW-1:0] rf_rdata;
    logic          rf_we;
    logic [AW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;

    always #10 clk = ~clk;

    split_exec_pipe #(.AW(AW), .DW(DW), .PW(PW)) u_dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    logic [IW-1:0] prog [64];
    logic [DW-1:0] rf [8];
    logic [DW-1:0] seed_rf [8];
    logic [DW-1:0] model [8];
    logic          rf_load = 1'b0;

    assign imem_data = prog[imem_addr];
    assign rf_rdata  = rf[rf_raddr];

    always @(posedge clk) begin
        if (rf_load) begin
            for (int i = 0; i < 8; i++) rf[i] <= seed_rf[i];
        end else if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] mk(input logic [3:0] op, input int src, input int dst);
        return {op, AW'(src), AW'(dst)};
    endfunction

    function automatic logic [DW-1:0] calc(input logic [3:0] op, input logic [DW-1:0] v);
        case (op)
            OP_MV:   return v;
            OP_S3:   return v - DW'(3);
            OP_A4:   return v + DW'(4);
            OP_A1:   return v + DW'(1);
            default: return v;
        endcase
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = '0;
    endtask

    task automatic do_reset(input bit check_it);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (check_it)
            check(imem_addr == 0 && rf_we == 1'b0, "R1", "reset pc/we",
                  {imem_addr, rf_we}, 0);
        for (int i = 0; i < 8; i++) seed_rf[i] = DW'($urandom);
        rf_load = 1'b1;
        @(negedge clk);
        rf_load = 1'b0;
        rst = 1'b0;
    endtask

    task automatic wait_addr(input int a, output int n);
        n = 0;
        while (int'(imem_addr) != a && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_compare(input string req, input string name);
        int n;
        int bad;
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) model[i] = seed_rf[i];
        for (int i = 0; i < 64; i++) begin
            if (prog[i][IW-1 -: 4] != 4'b0)
                model[prog[i][AW-1:0]] = calc(prog[i][IW-1 -: 4], model[prog[i][2*AW-1 -: AW]]);
        end
        wait_addr(56, n);
        repeat (2) @(negedge clk);
        bad = -1;
        for (int i = 0; i < 8; i++) if (bad < 0 && rf[i] !== model[i]) bad = i;
        if (bad < 0) check(1'b1, req, name, 0, 0);
        else check(1'b0, req, $sformatf("%s reg%0d", name, bad), rf[bad], model[bad]);
    endtask

    task automatic timed(input string name, input int expect_n);
        int n0;
        int n;
        do_reset(1'b0);
        wait_addr(3, n0);
        wait_addr(11, n);
        check(n == expect_n, "R3", name, n, expect_n);
    endtask

    initial begin
        #3000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd457));
        clear_prog();
        do_reset(1'b1);                          // R1 reset state

        // R2: independent operations
        clear_prog();
        prog[0] = mk(OP_MV, 0, 4); prog[1] = mk(OP_S3, 1, 5);
        prog[2] = mk(OP_A4, 2, 6); prog[3] = mk(OP_A1, 3, 7);
        run_compare("R2", "independent ops");

        // R4: each instruction reads the previous destination
        clear_prog();
        prog[0] = mk(OP_S3, 1, 1); prog[1] = mk(OP_A4, 1, 1);
        prog[2] = mk(OP_MV, 1, 2); prog[3] = mk(OP_A1, 2, 2);
        prog[4] = mk(OP_S3, 2, 2); prog[5] = mk(OP_A4, 2, 3);
        prog[6] = mk(OP_MV, 3, 1);
        run_compare("R4", "adjacent chain");

        // R5: dependence two places back
        clear_prog();
        prog[0] = mk(OP_A4, 0, 1); prog[1] = mk(OP_MV, 5, 6);
        prog[2] = mk(OP_S3, 1, 2); prog[3] = mk(OP_MV, 6, 7);
        prog[4] = mk(OP_A1, 2, 3); prog[5] = mk(OP_S3, 4, 4);
        prog[6] = mk(OP_A4, 3, 0);
        run_compare("R5", "distance two chain");

        // R3 / R6: back-to-back dependent add-one
        clear_prog();
        for (int i = 0; i < 6; i++) prog[i] = mk(OP_A1, 0, 0);
        prog[6] = mk(OP_A1, 0, 1);
        run_compare("R6", "add-one chain");

        // R6: add-one as junior and as senior
        clear_prog();
        prog[0] = mk(OP_A4, 2, 2); prog[1] = mk(OP_A1, 2, 2);
        prog[2] = mk(OP_MV, 2, 3); prog[3] = mk(OP_A1, 3, 3);
        prog[4] = mk(OP_A1, 3, 4); prog[5] = mk(OP_S3, 4, 4);
        run_compare("R6", "add-one forwarding");

        // R7: no-operations naming live registers
        clear_prog();
        prog[0] = mk(OP_A4, 1, 1); prog[1] = mk(4'b0, 1, 2);
        prog[2] = mk(OP_MV, 2, 3); prog[3] = mk(4'b0, 3, 1);
        prog[4] = mk(OP_S3, 1, 5); prog[5] = mk(4'b0, 5, 6);
        prog[6] = mk(OP_MV, 6, 7);
        run_compare("R7", "no-operation bubbles");

        // R3: stall clock counts
        clear_prog();
        for (int i = 0; i < 48; i++) prog[i] = mk(OP_A1, i % 8, i % 8);
        timed("add-one only", 16);
        clear_prog();
        for (int i = 0; i < 48; i++) prog[i] = mk(OP_MV, i % 8, (i + 1) % 8);
        timed("copy only", 8);
        clear_prog();
        for (int i = 0; i < 48; i++) prog[i] = mk((i % 2 == 0) ? OP_A1 : OP_MV, i % 4, i % 4);
        timed("alternating", 12);

        // R8: seeded random programs
        for (int p = 0; p < 6; p++) begin
            clear_prog();
            for (int i = 0; i < 48; i++) begin
                int r;
                logic [3:0] op;
                r = $urandom % 8;
                op = (r == 7) ? 4'b0 : (4'b0001 << (r % 4));
                prog[i] = mk(op, $urandom % 4, $urandom % 4);
            end
            run_compare("R8", $sformatf("random program %0d", p));
        end

        // R1: reset in the middle of a program
        do_reset(1'b0);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(imem_addr == 0 && rf_we == 1'b0, "R1", "mid-run reset",
              {imem_addr, rf_we}, 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule